// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel NOR flash that uses the common single-supply command set. It watches synchronous bus write strobes (address plus data) and turns keyed multi-write sequences into one-cycle requests for the array engine: program (with the latched address and data), chip erase, sector erase (with the sector number), erase suspend, erase resume and reset. It also keeps an identification mode, in which a read address selects a manufacturer code, a device code or the protection bit of a sector.

Each keyed sequence opens with a two-write unlock pair, and only the low twelve address bits take part in matching unlock and command addresses. A per-cycle gap counter, sized by a parameter in clock cycles, drops a sequence whose next write comes too late; a write that arrives after expiry is decoded as the first write of a new sequence. A wrong address or data value at any step drops the sequence without a request. The array engine reports through `eraseBusy` whether an erase is running, so that suspend and resume are only accepted when meaningful.

Top module: `flash_cmd_decoder`

## Requirements
- R1: An unlock pair is data AA written where address bits [11:0] equal AAA, then data 55 where bits [11:0] equal 555; higher address bits have no effect on matching.
- R2: After an unlock pair, data 90 at AAA sets `asMode`; in that mode `idData` gives 37 for read offset `rdAddr[7:0]`=00, `DEV_ID` for 01, `{7'b0, protMask[rdAddr[ADDR_W-1:SECT_LSB]]}` for 02 and 00 otherwise; `idData` is 00 outside the mode, and every write except data F0 is ignored in the mode.
- R3: After an unlock pair, data A0 at AAA arms a program; the next write, whatever its data (F0 included), raises `pgmStb` for the cycle after that write with `pgmAddr`/`pgmData` equal to its address and data.
- R4: After an unlock pair, data 80 at AAA, a second unlock pair and data 10 at AAA raise `chipErsStb`.
- R5: The same prefix followed by data 30 at any address raises `secErsStb` with `secAddr` equal to that address's bits [ADDR_W-1:SECT_LSB].
- R6: Data F0 at any address, except as program data, raises `rstStb`, returns the decoder to idle and clears `asMode`.
- R7: Data B0 written while idle, with `eraseBusy` high and no suspension pending, raises `suspStb` and sets `ersSusp`; otherwise it has no effect.
- R8: Data 30 written while idle with `ersSusp` set raises `resmStb` and clears `ersSusp`; otherwise it has no effect.
- R9: Any write that does not match the expected address and data of the current step ends the sequence with no strobe, and that write is consumed.
- R10: A write at most `TIMEOUT_CYC` cycles after the previous write continues a sequence; a later one finds the sequence dropped and is decoded from idle.
- R11: All strobes last one cycle, appear in the cycle after the deciding write, and at most one is high at a time.
- R12: While `ersSusp` is set, the erase setup data 80 ends the sequence, so no erase request is issued; program sequences still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | One-cycle bus write strobe |
| busAddr | input | ADDR_W | Byte address of the write |
| busData | input | 8 | Data of the write |
| eraseBusy | input | 1 | Array engine is running an erase |
| rdAddr | input | ADDR_W | Read address for identification data |
| protMask | input | 2**(ADDR_W-SECT_LSB) | Protection bit per sector |
| pgmStb | output | 1 | Program request |
| pgmAddr | output | ADDR_W | Program address |
| pgmData | output | 8 | Program data |
| chipErsStb | output | 1 | Chip erase request |
| secErsStb | output | 1 | Sector erase request |
| secAddr | output | ADDR_W-SECT_LSB | Sector number to erase |
| suspStb | output | 1 | Erase suspend request |
| resmStb | output | 1 | Erase resume request |
| rstStb | output | 1 | Return to array-read request |
| asMode | output | 1 | Identification mode active |
| ersSusp | output | 1 | An erase is suspended |
| idData | output | 8 | Identification read data |

## Verification
The two functions that can meet in one cycle are the gap timer running out and a new write arriving. The bench spaces writes exactly `TIMEOUT_CYC` and `TIMEOUT_CYC`+1 cycles apart, with a small limit, and judges the outcome by whether a later program write produces `pgmStb`, or whether a restarted unlock completes. A second overlap, data F0 landing on the program-data step, is judged by seeing `pgmStb` with data F0 rather than `rstStb`. Sweeps over all 256 data values at the command step and at the final erase step compare every strobe against a table built in the bench.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int CMP_W = 12;

  localparam logic [CMP_W-1:0] ADDR_KEY1 = 12'hAAA;
  localparam logic [CMP_W-1:0] ADDR_KEY2 = 12'h555;

  localparam logic [7:0] D_KEY1    = 8'hAA;
  localparam logic [7:0] D_KEY2    = 8'h55;
  localparam logic [7:0] D_IDENT   = 8'h90;
  localparam logic [7:0] D_PROG    = 8'hA0;
  localparam logic [7:0] D_ESETUP  = 8'h80;
  localparam logic [7:0] D_CHIP    = 8'h10;
  localparam logic [7:0] D_SECTOR  = 8'h30;
  localparam logic [7:0] D_SUSPEND = 8'hB0;
  localparam logic [7:0] D_RESUME  = 8'h30;
  localparam logic [7:0] D_RESET   = 8'hF0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_PROG,
    ST_ESET,
    ST_EKEY1,
    ST_EKEY2
  } seqState_t;

  typedef struct packed {
    logic capPgm;
    logic capSec;
  } fcdCtl_t;

endpackage

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int SECT_LSB    = 16,
  parameter int TIMEOUT_CYC = 2000,
  parameter logic [7:0] MFR_ID = 8'h37,
  parameter logic [7:0] DEV_ID = 8'h51
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             busWr,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic [7:0]                       busData,
  input  fcdCtl_t                          ctl,
  input  logic [ADDR_W-1:0]                rdAddr,
  input  logic [(1<<(ADDR_W-SECT_LSB))-1:0] protMask,
  input  logic                             asMode,
  output logic                             hitKey1,
  output logic                             hitKey2,
  output logic                             expired,
  output logic [ADDR_W-1:0]                pgmAddr,
  output logic [7:0]                       pgmData,
  output logic [ADDR_W-SECT_LSB-1:0]       secAddr,
  output logic [7:0]                       idData
);

  localparam int SECT_W = ADDR_W - SECT_LSB;
  localparam int CNT_W  = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TIMEOUT_CYC);

  logic [CNT_W-1:0] gapCnt;
  logic [SECT_W-1:0] rdSect;
  logic [7:0] rdOff;

  assign hitKey1 = (busAddr[CMP_W-1:0] == ADDR_KEY1);
  assign hitKey2 = (busAddr[CMP_W-1:0] == ADDR_KEY2);
  assign expired = (gapCnt == CNT_MAX);

  // cycles since the last bus write, saturating at the limit
  always_ff @(posedge clk) begin
    if (!rstN)            gapCnt <= '0;
    else if (busWr)       gapCnt <= '0;
    else if (!expired)    gapCnt <= gapCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pgmAddr <= '0;
      pgmData <= '0;
      secAddr <= '0;
    end else begin
      if (ctl.capPgm) begin
        pgmAddr <= busAddr;
        pgmData <= busData;
      end
      if (ctl.capSec) secAddr <= busAddr[ADDR_W-1:SECT_LSB];
    end
  end

  assign rdSect = rdAddr[ADDR_W-1:SECT_LSB];
  assign rdOff  = rdAddr[7:0];

  always_comb begin
    idData = 8'h00;
    if (asMode) begin
      case (rdOff)
        8'h00:   idData = MFR_ID;
        8'h01:   idData = DEV_ID;
        8'h02:   idData = {7'b0, protMask[rdSect]};
        default: idData = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic [7:0] busData,
  input  logic       hitKey1,
  input  logic       hitKey2,
  input  logic       expired,
  input  logic       eraseBusy,
  output fcdCtl_t    ctl,
  output logic       pgmStb,
  output logic       chipErsStb,
  output logic       secErsStb,
  output logic       suspStb,
  output logic       resmStb,
  output logic       rstStb,
  output logic       asMode,
  output logic       ersSusp
);

  seqState_t state, nState, effState;
  logic nAs, nSusp;
  logic nPgm, nChip, nSec, nSusStb, nRes, nRst;

  // a timed-out sequence is seen as idle by the write in the same cycle
  assign effState = (expired && state != ST_IDLE) ? ST_IDLE : state;

  always_comb begin
    nState  = effState;
    nAs     = asMode;
    nSusp   = ersSusp;
    nPgm    = 1'b0;
    nChip   = 1'b0;
    nSec    = 1'b0;
    nSusStb = 1'b0;
    nRes    = 1'b0;
    nRst    = 1'b0;
    ctl     = '0;
    if (busWr) begin
      if (effState == ST_PROG) begin
        nPgm       = 1'b1;
        ctl.capPgm = 1'b1;
        nState     = ST_IDLE;
      end else if (busData == D_RESET) begin
        nRst   = 1'b1;
        nAs    = 1'b0;
        nState = ST_IDLE;
      end else if (asMode) begin
        nState = ST_IDLE;
      end else begin
        nState = ST_IDLE;
        unique case (effState)
          ST_IDLE: begin
            if (hitKey1 && busData == D_KEY1) begin
              nState = ST_KEY1;
            end else if (busData == D_SUSPEND) begin
              if (eraseBusy && !ersSusp) begin
                nSusStb = 1'b1;
                nSusp   = 1'b1;
              end
            end else if (busData == D_RESUME) begin
              if (ersSusp) begin
                nRes  = 1'b1;
                nSusp = 1'b0;
              end
            end
          end
          ST_KEY1: begin
            if (hitKey2 && busData == D_KEY2) nState = ST_KEY2;
          end
          ST_KEY2: begin
            if (hitKey1) begin
              if (busData == D_IDENT)                    nAs    = 1'b1;
              else if (busData == D_PROG)                nState = ST_PROG;
              else if (busData == D_ESETUP && !ersSusp)  nState = ST_ESET;
            end
          end
          ST_ESET: begin
            if (hitKey1 && busData == D_KEY1) nState = ST_EKEY1;
          end
          ST_EKEY1: begin
            if (hitKey2 && busData == D_KEY2) nState = ST_EKEY2;
          end
          ST_EKEY2: begin
            if (hitKey1 && busData == D_CHIP) begin
              nChip = 1'b1;
            end else if (busData == D_SECTOR) begin
              nSec       = 1'b1;
              ctl.capSec = 1'b1;
            end
          end
          default: nState = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      asMode     <= 1'b0;
      ersSusp    <= 1'b0;
      pgmStb     <= 1'b0;
      chipErsStb <= 1'b0;
      secErsStb  <= 1'b0;
      suspStb    <= 1'b0;
      resmStb    <= 1'b0;
      rstStb     <= 1'b0;
    end else begin
      state      <= nState;
      asMode     <= nAs;
      ersSusp    <= nSusp;
      pgmStb     <= nPgm;
      chipErsStb <= nChip;
      secErsStb  <= nSec;
      suspStb    <= nSusStb;
      resmStb    <= nRes;
      rstStb     <= nRst;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int SECT_LSB    = 16,
  parameter int TIMEOUT_CYC = 2000,
  parameter logic [7:0] MFR_ID = 8'h37,
  parameter logic [7:0] DEV_ID = 8'h51
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              busWr,
  input  logic [ADDR_W-1:0]                 busAddr,
  input  logic [7:0]                        busData,
  input  logic                              eraseBusy,
  input  logic [ADDR_W-1:0]                 rdAddr,
  input  logic [(1<<(ADDR_W-SECT_LSB))-1:0] protMask,
  output logic                              pgmStb,
  output logic [ADDR_W-1:0]                 pgmAddr,
  output logic [7:0]                        pgmData,
  output logic                              chipErsStb,
  output logic                              secErsStb,
  output logic [ADDR_W-SECT_LSB-1:0]        secAddr,
  output logic                              suspStb,
  output logic                              resmStb,
  output logic                              rstStb,
  output logic                              asMode,
  output logic                              ersSusp,
  output logic [7:0]                        idData
);

  fcdCtl_t ctl;
  logic hitKey1, hitKey2, expired;

  fcd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWr      (busWr),
    .busData    (busData),
    .hitKey1    (hitKey1),
    .hitKey2    (hitKey2),
    .expired    (expired),
    .eraseBusy  (eraseBusy),
    .ctl        (ctl),
    .pgmStb     (pgmStb),
    .chipErsStb (chipErsStb),
    .secErsStb  (secErsStb),
    .suspStb    (suspStb),
    .resmStb    (resmStb),
    .rstStb     (rstStb),
    .asMode     (asMode),
    .ersSusp    (ersSusp)
  );

  fcd_datapath #(
    .ADDR_W      (ADDR_W),
    .SECT_LSB    (SECT_LSB),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .MFR_ID      (MFR_ID),
    .DEV_ID      (DEV_ID)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busData  (busData),
    .ctl      (ctl),
    .rdAddr   (rdAddr),
    .protMask (protMask),
    .asMode   (asMode),
    .hitKey1  (hitKey1),
    .hitKey2  (hitKey2),
    .expired  (expired),
    .pgmAddr  (pgmAddr),
    .pgmData  (pgmData),
    .secAddr  (secAddr),
    .idData   (idData)
  );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W   = 19,
  parameter int SECT_LSB = 16
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        busWr,
  input logic [ADDR_W-1:0]           busAddr,
  input logic [7:0]                  busData,
  input logic                        eraseBusy,
  input logic                        pgmStb,
  input logic [ADDR_W-1:0]           pgmAddr,
  input logic [7:0]                  pgmData,
  input logic                        chipErsStb,
  input logic                        secErsStb,
  input logic [ADDR_W-SECT_LSB-1:0]  secAddr,
  input logic                        suspStb,
  input logic                        resmStb,
  input logic                        rstStb,
  input logic                        asMode,
  input logic                        ersSusp
);

  logic [5:0] strb;
  assign strb = {pgmStb, chipErsStb, secErsStb, suspStb, resmStb, rstStb};

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  a_r11_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (|strb) |-> $past(busWr));

  a_r3_pgm_payload: assert property (@(posedge clk) disable iff (!rstN)
    pgmStb |-> (pgmAddr == $past(busAddr) && pgmData == $past(busData)));

  a_r4_chip_key: assert property (@(posedge clk) disable iff (!rstN)
    chipErsStb |-> ($past(busData) == 8'h10 && $past(busAddr[11:0]) == 12'hAAA));

  a_r5_sector_addr: assert property (@(posedge clk) disable iff (!rstN)
    secErsStb |-> (secAddr == $past(busAddr[ADDR_W-1:SECT_LSB]) && $past(busData) == 8'h30));

  a_r6_reset_exit: assert property (@(posedge clk) disable iff (!rstN)
    rstStb |-> !asMode);

  a_r7_suspend: assert property (@(posedge clk) disable iff (!rstN)
    suspStb |-> (ersSusp && !$past(ersSusp) && $past(eraseBusy)));

  a_r8_resume: assert property (@(posedge clk) disable iff (!rstN)
    resmStb |-> (!ersSusp && $past(ersSusp)));

  a_r2_ident_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asMode) |-> ($past(busWr) && $past(busData) == 8'h90));

  a_r12_no_erase_suspended: assert property (@(posedge clk) disable iff (!rstN)
    (chipErsStb || secErsStb) |-> !$past(ersSusp));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .ADDR_W   (ADDR_W),
  .SECT_LSB (SECT_LSB)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busWr      (busWr),
  .busAddr    (busAddr),
  .busData    (busData),
  .eraseBusy  (eraseBusy),
  .pgmStb     (pgmStb),
  .pgmAddr    (pgmAddr),
  .pgmData    (pgmData),
  .chipErsStb (chipErsStb),
  .secErsStb  (secErsStb),
  .secAddr    (secAddr),
  .suspStb    (suspStb),
  .resmStb    (resmStb),
  .rstStb     (rstStb),
  .asMode     (asMode),
  .ersSusp    (ersSusp)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

  localparam int AW  = 16;
  localparam int SL  = 13;
  localparam int NS  = 1 << (AW - SL);
  localparam int TO  = 8;
  localparam logic [7:0] DEVID = 8'h5C;

  localparam logic [5:0] E_NONE = 6'b000000;
  localparam logic [5:0] E_PGM  = 6'b100000;
  localparam logic [5:0] E_CHIP = 6'b010000;
  localparam logic [5:0] E_SEC  = 6'b001000;
  localparam logic [5:0] E_SUS  = 6'b000100;
  localparam logic [5:0] E_RES  = 6'b000010;
  localparam logic [5:0] E_RST  = 6'b000001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [7:0] busData = '0;
  logic eraseBusy = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [NS-1:0] protMask = 8'b1010_0110;
  logic pgmStb, chipErsStb, secErsStb, suspStb, resmStb, rstStb, asMode, ersSusp;
  logic [AW-1:0] pgmAddr;
  logic [7:0] pgmData, idData;
  logic [AW-SL-1:0] secAddr;

  int nChecks = 0;
  int nFails  = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flash_cmd_decoder #(
    .ADDR_W(AW), .SECT_LSB(SL), .TIMEOUT_CYC(TO), .MFR_ID(8'h37), .DEV_ID(DEVID)
  ) u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busData(busData),
    .eraseBusy(eraseBusy), .rdAddr(rdAddr), .protMask(protMask),
    .pgmStb(pgmStb), .pgmAddr(pgmAddr), .pgmData(pgmData),
    .chipErsStb(chipErsStb), .secErsStb(secErsStb), .secAddr(secAddr),
    .suspStb(suspStb), .resmStb(resmStb), .rstStb(rstStb),
    .asMode(asMode), .ersSusp(ersSusp), .idData(idData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] strobes();
    return {pgmStb, chipErsStb, secErsStb, suspStb, resmStb, rstStb};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    busAddr = a; busData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(16'h0AAA, 8'hAA);
    wr(16'h0555, 8'h55);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    gap(3);
    rstN = 1'b1;
    gap(1);
    // reset state
    chk("R11 reset strobes", 32'(strobes()), 32'(E_NONE));
    chk("R2 reset asMode", 32'(asMode), 0);
    chk("R7 reset ersSusp", 32'(ersSusp), 0);
    chk("R2 idData outside mode", 32'(idData), 0);

    // R2 R3 R4 R6 R9: sweep every data value at the command step
    for (int d = 0; d < 256; d++) begin
      wr(16'h0000, 8'hF0);
      unlock();
      wr(16'h0AAA, 8'(d));
      chk("R9 command step strobes", 32'(strobes()), (d == 8'hF0) ? 32'(E_RST) : 32'(E_NONE));
      chk("R2 ident entry", 32'(asMode), (d == 8'h90) ? 1 : 0);
      if (d == 8'hA0) begin
        wr(16'h1234, 8'h5A);
        chk("R3 program strobe", 32'(strobes()), 32'(E_PGM));
        chk("R3 program addr", 32'(pgmAddr), 32'h1234);
        chk("R3 program data", 32'(pgmData), 32'h5A);
        gap(1);
        chk("R11 single cycle", 32'(strobes()), 32'(E_NONE));
      end else if (d == 8'h80) begin
        unlock();
        wr(16'hFAAA, 8'h10);
        chk("R4 chip erase", 32'(strobes()), 32'(E_CHIP));
      end else begin
        wr(16'h0040, 8'hC3);
        chk("R9 aborted no program", 32'(strobes()), 32'(E_NONE));
      end
    end

    // R5 R4 R9: sweep every data value at the final erase step
    for (int d = 0; d < 256; d++) begin
      wr(16'h0000, 8'hF0);
      unlock();
      wr(16'h0AAA, 8'h80);
      unlock();
      wr(16'h6AAA, 8'(d));
      chk("R5 final step strobes", 32'(strobes()),
          (d == 8'h10) ? 32'(E_CHIP) : (d == 8'h30) ? 32'(E_SEC) :
          (d == 8'hF0) ? 32'(E_RST) : 32'(E_NONE));
      if (d == 8'h30) chk("R5 sector number", 32'(secAddr), 3);
    end
    unlock(); wr(16'h0AAA, 8'h80); unlock();
    wr(16'h0AAB, 8'h10);
    chk("R4 chip erase needs AAA", 32'(strobes()), 32'(E_NONE));

    // R1: upper address bits ignored, low bits matter
    wr(16'hFAAA, 8'hAA); wr(16'hE555, 8'h55); wr(16'h7AAA, 8'hA0); wr(16'h0010, 8'h11);
    chk("R1 high bits ignored", 32'(strobes()), 32'(E_PGM));
    wr(16'h0AAB, 8'hAA); wr(16'h0555, 8'h55); wr(16'h0AAA, 8'hA0); wr(16'h0010, 8'h11);
    chk("R1 wrong low address", 32'(strobes()), 32'(E_NONE));
    wr(16'h0AAA, 8'hAA); wr(16'h0554, 8'h55); wr(16'h0AAA, 8'hA0); wr(16'h0010, 8'h11);
    chk("R1 wrong second address", 32'(strobes()), 32'(E_NONE));

    // R2: identification reads over all sectors
    wr(16'h0000, 8'hF0);
    unlock(); wr(16'h0AAA, 8'h90);
    for (int s = 0; s < NS; s++) begin
      rdAddr = AW'((s << SL) | 2); #1;
      chk("R2 protect bit", 32'(idData), 32'(protMask[s]));
      rdAddr = AW'((s << SL) | 0); #1;
      chk("R2 maker code", 32'(idData), 32'h37);
      rdAddr = AW'((s << SL) | 1); #1;
      chk("R2 device code", 32'(idData), 32'(DEVID));
      rdAddr = AW'((s << SL) | 3); #1;
      chk("R2 other offset", 32'(idData), 0);
    end
    unlock(); wr(16'h0AAA, 8'hA0); wr(16'h0010, 8'h22);
    chk("R2 writes ignored in mode", 32'(strobes()), 32'(E_NONE));
    chk("R2 mode kept", 32'(asMode), 1);
    wr(16'h3333, 8'hF0);
    chk("R6 reset strobe", 32'(strobes()), 32'(E_RST));
    chk("R6 mode left", 32'(asMode), 0);
    rdAddr = '0; #1;
    chk("R2 idData after exit", 32'(idData), 0);

    // R3 vs R6: F0 on the program-data step is data
    unlock(); wr(16'h0AAA, 8'hA0); wr(16'h0777, 8'hF0);
    chk("R3 F0 as program data", 32'(strobes()), 32'(E_PGM));
    chk("R3 F0 data value", 32'(pgmData), 32'hF0);
    wr(16'h0AAA, 8'hAA); wr(16'h0123, 8'hF0);
    chk("R6 reset mid unlock", 32'(strobes()), 32'(E_RST));
    wr(16'h0AAA, 8'hA0); wr(16'h0010, 8'h11);
    chk("R6 back to idle", 32'(strobes()), 32'(E_NONE));

    // R7 R8 R12: suspend and resume
    wr(16'h0000, 8'h30);
    chk("R8 resume ignored", 32'(strobes()), 32'(E_NONE));
    wr(16'h0000, 8'hB0);
    chk("R7 suspend without erase", 32'(strobes()), 32'(E_NONE));
    chk("R7 no suspension", 32'(ersSusp), 0);
    eraseBusy = 1'b1;
    wr(16'h4321, 8'hB0);
    chk("R7 suspend strobe", 32'(strobes()), 32'(E_SUS));
    chk("R7 suspended", 32'(ersSusp), 1);
    wr(16'h0000, 8'hB0);
    chk("R7 second suspend ignored", 32'(strobes()), 32'(E_NONE));
    unlock(); wr(16'h0AAA, 8'hA0); wr(16'h0099, 8'h44);
    chk("R12 program while suspended", 32'(strobes()), 32'(E_PGM));
    unlock(); wr(16'h0AAA, 8'h80);
    unlock(); wr(16'h0AAA, 8'h10);
    chk("R12 erase blocked", 32'(strobes()), 32'(E_NONE));
    chk("R12 still suspended", 32'(ersSusp), 1);
    wr(16'h5555, 8'h30);
    chk("R8 resume strobe", 32'(strobes()), 32'(E_RES));
    chk("R8 resumed", 32'(ersSusp), 0);
    wr(16'h5555, 8'h30);
    chk("R8 second resume ignored", 32'(strobes()), 32'(E_NONE));
    eraseBusy = 1'b0;

    // R10: gap limit and write in the expiry cycle
    wr(16'h0AAA, 8'hAA); gap(TO-1); wr(16'h0555, 8'h55); gap(TO-1);
    wr(16'h0AAA, 8'hA0); gap(TO-1); wr(16'h0020, 8'h66);
    chk("R10 gap at limit", 32'(strobes()), 32'(E_PGM));
    wr(16'h0AAA, 8'hAA); wr(16'h0555, 8'h55); gap(TO);
    wr(16'h0AAA, 8'hA0); wr(16'h0020, 8'h66);
    chk("R10 gap over limit", 32'(strobes()), 32'(E_NONE));
    wr(16'h0AAA, 8'hAA); gap(TO);
    wr(16'h0AAA, 8'hAA); wr(16'h0555, 8'h55); wr(16'h0AAA, 8'hA0); wr(16'h0030, 8'h77);
    chk("R10 restart after expiry", 32'(strobes()), 32'(E_PGM));
    unlock(); wr(16'h0AAA, 8'hA0); gap(TO);
    wr(16'h0030, 8'h77);
    chk("R10 program step expired", 32'(strobes()), 32'(E_NONE));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule